// File: doc/BRIEF.md
# Scanned Keyboard Matrix Emulator

This block stands in for a physical key matrix in front of a host scanner. The host drives a vector of strobe (column) lines and reads back a vector of sense (row) lines. Key events arrive as 8-bit codes. Each code is queued in a small circular buffer and handed to the matrix at a slow, fixed tick rate, so the host scanner always has time to see every change.

When a code is taken from the buffer, its low seven bits address a key-position table. The table gives the row in the upper nibble and the column in the lower nibble. The code's top bit tells whether the key is pressed or released, and that sets or clears one bit of the row's pressed-column bitmap. One reserved row does not feed the matrix: the keys in that row drive a handful of direct button lines instead.

A sense line is high whenever its row has a pressed key on a strobe line that is currently driven. A clear input releases every key and button, and it empties the buffer.

Top module: `keymat_emu`

## Requirements
- R1: After reset, all sense lines, button lines and the overflow flag are low, and the event buffer is empty.
- R2: Sense line r equals the OR, over all columns c, of (row r has column c pressed AND strobe c is high). A strobe change shows on the sense lines in the same cycle, with no register in the path.
- R3: A table entry holds the row in bits 7:4 and the column in bits 3:0. The value 8'hFF marks an unmapped code, and its event changes nothing. The default table maps code 0 and codes above 82 to 8'hFF. Every other code k is handled with n = k-1. For n < 77, the row is n/11 and the column is n%11. For n from 77 to 81, the row is 7 and the column is n-77.
- R4: Bit 7 of a code set to 1 means release, which clears the bitmap bit. Bit 7 set to 0 means press, which sets the bit. Only bits 6:0 address the table.
- R5: When the looked-up row is 7, the column selects a button line (0 to 4). That line goes high on a press and low on a release, and the sense lines are not touched.
- R6: An accepted event enters a 16-entry FIFO. A tick pulse occurs once every TICK_DIV clock cycles, first on the TICK_DIV-th cycle after reset. On the clock edge of a tick cycle with a non-empty FIFO, exactly one entry is consumed and applied. No event takes effect in the cycle it is offered.
- R7: A clear cycle empties the FIFO, releases all matrix keys and buttons, and lowers the overflow flag, all on the next edge. An event offered in the same cycle is discarded.
- R8: An event offered while the FIFO holds 16 entries is dropped. The overflow flag is then set and stays high until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Key event offered this cycle |
| evt_code | input | 8 | Key code; bit 7 = release |
| clear | input | 1 | Release all keys and empty the buffer |
| strobe_i | input | 11 | Host-driven strobe (column) lines |
| sense_o | output | 7 | Row sense lines to the host |
| button_o | output | 5 | Direct button lines |
| overflow_o | output | 1 | Sticky buffer-overflow flag |

## Verification
Sense lines are combinational in the strobes, so they are compared in the same cycle the strobe vector changes. A key's effect on sense or button lines is due immediately after the clock edge of the tick cycle that consumes it; an offered event is never visible before that. Overflow and clear take effect one edge after the offending cycle. The bench drives inputs at the falling edge and samples 1 ns later, against a cycle model that advances on each rising edge.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
    localparam int CODE_W    = 8;
    localparam int MAP_SIZE  = 128;
    localparam int N_STROBE  = 11;
    localparam int N_SENSE   = 7;
    localparam int N_BUTTON  = 5;
    localparam int BTN_ROW   = 7;
    localparam logic [CODE_W-1:0] UNMAPPED = 8'hFF;

    // Row-major default placement: code k -> slot k-1, then the button row.
    function automatic logic [MAP_SIZE*CODE_W-1:0] default_keymap();
        logic [MAP_SIZE*CODE_W-1:0] m;
        int n;
        m = '1;
        for (int k = 1; k < MAP_SIZE; k++) begin
            n = k - 1;
            if (n < N_SENSE * N_STROBE)
                m[k*CODE_W +: CODE_W] = {4'(n / N_STROBE), 4'(n % N_STROBE)};
            else if (n < N_SENSE * N_STROBE + N_BUTTON)
                m[k*CODE_W +: CODE_W] = {4'(BTN_ROW), 4'(n - N_SENSE * N_STROBE)};
        end
        return m;
    endfunction
endpackage

// File: rtl/keymat_fifo.sv
module keymat_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign full  = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !empty;
        do_push = push && !full;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_pop)
                st_d.rd = st_q.rd + 1'b1;
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = st_q.wr + 1'b1;
            end
            if (do_push && !do_pop)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (do_pop && !do_push)
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/keymat_tick.sv
module keymat_tick #(
    parameter int DIV   = 1000,
    localparam int CW   = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/keymat_lookup.sv
module keymat_lookup #(
    parameter int ENTRIES = 128,
    parameter int W       = 8,
    parameter logic [ENTRIES*W-1:0] TABLE = '1,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  pos
);
    logic [W-1:0] rom [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
        assign rom[i] = TABLE[i*W +: W];
    end

    assign pos = rom[idx];
endmodule

// File: rtl/keymat_matrix.sv
module keymat_matrix #(
    parameter int NSENSE  = 7,
    parameter int NSTROBE = 11,
    parameter int NBTN    = 5,
    parameter int BROW    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic [7:0]         pos,
    input  logic               release_i,
    input  logic               flush,
    input  logic [NSTROBE-1:0] strobe,
    output logic [NSENSE-1:0]  sense,
    output logic [NBTN-1:0]    button
);
    typedef struct packed {
        logic [NSENSE-1:0][NSTROBE-1:0] rows;
        logic [NBTN-1:0]                btn;
    } mat_st_t;

    mat_st_t st_d, st_q;
    logic [3:0] row_sel, col_sel;

    assign row_sel = pos[7:4];
    assign col_sel = pos[3:0];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (apply && pos != 8'hFF) begin
            if (row_sel == 4'(BROW)) begin
                for (int j = 0; j < NBTN; j++)
                    if (col_sel == 4'(j)) st_d.btn[j] = !release_i;
            end else begin
                for (int i = 0; i < NSENSE; i++)
                    for (int j = 0; j < NSTROBE; j++)
                        if (row_sel == 4'(i) && col_sel == 4'(j))
                            st_d.rows[i][j] = !release_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar r = 0; r < NSENSE; r++) begin : g_sense
        assign sense[r] = |(st_q.rows[r] & strobe);
    end

    assign button = st_q.btn;
endmodule

// File: rtl/keymat_emu.sv
module keymat_emu
    import keymat_pkg::*;
#(
    parameter int TICK_DIV   = 1000,
    parameter int FIFO_DEPTH = 16,
    parameter logic [MAP_SIZE*CODE_W-1:0] KEYMAP = default_keymap(),
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [CODE_W-1:0]   evt_code,
    input  logic                clear,
    input  logic [N_STROBE-1:0] strobe_i,
    output logic [N_SENSE-1:0]  sense_o,
    output logic [N_BUTTON-1:0] button_o,
    output logic                overflow_o
);
    logic              tick;
    logic [CODE_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;
    logic [CODE_W-1:0] key_pos;
    logic              ovf_d, ovf_q;

    keymat_tick #(.DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    keymat_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(evt_valid && !clear), .push_data(evt_code),
        .pop(tick), .flush(clear),
        .head(head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    keymat_lookup #(.ENTRIES(MAP_SIZE), .W(CODE_W), .TABLE(KEYMAP)) lut_i (
        .idx(head[6:0]), .pos(key_pos)
    );

    keymat_matrix #(.NSENSE(N_SENSE), .NSTROBE(N_STROBE),
                    .NBTN(N_BUTTON), .BROW(BTN_ROW)) mat_i (
        .clk(clk), .rst_n(rst_n),
        .apply(tick && !fifo_empty), .pos(key_pos), .release_i(head[7]),
        .flush(clear), .strobe(strobe_i),
        .sense(sense_o), .button(button_o)
    );

    always_comb begin
        ovf_d = clear ? 1'b0 : (ovf_q || (evt_valid && fifo_full));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign overflow_o = ovf_q;
endmodule

// File: rtl/keymat_emu_chk.sv
module keymat_emu_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        evt_valid,
    input logic [10:0] strobe_i,
    input logic [6:0]  sense_o,
    input logic [4:0]  button_o,
    input logic        overflow_o,
    input logic [CW-1:0] fifo_cnt,
    input logic        tick
);
    // R2: no strobe driven means no sense
    p_idle_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |-> (sense_o == '0));

    // R5: buttons move only on a tick edge or a clear
    p_button_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(button_o));

    // R6: FIFO never above its depth
    p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R6: at most one entry leaves per cycle without a clear
    p_one_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ({1'b0, fifo_cnt} + 1'b1 >= {1'b0, $past(fifo_cnt)}));

    // R7: clear empties the buffer and releases everything
    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fifo_cnt == '0 && sense_o == '0 && button_o == '0 && !overflow_o));

    // R8: overflow is sticky until clear
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clear) |=> overflow_o);

    // R8: overflow rises only after an offered event
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(evt_valid));
endmodule

bind keymat_emu keymat_emu_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evt_valid(evt_valid),
    .strobe_i(strobe_i), .sense_o(sense_o), .button_o(button_o),
    .overflow_o(overflow_o), .fifo_cnt(fifo_cnt), .tick(tick)
);

// File: tb/keymat_emu_tb_top.sv
module keymat_emu_tb_top;
    localparam int DIV = 6;
    localparam int DEP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_code = '0;
    logic        clear = 1'b0;
    logic [10:0] strobe_i = '0;
    logic [6:0]  sense_o;
    logic [4:0]  button_o;
    logic        overflow_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    keymat_emu #(.TICK_DIV(DIV), .FIFO_DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
        .clear(clear), .strobe_i(strobe_i), .sense_o(sense_o),
        .button_o(button_o), .overflow_o(overflow_o)
    );

    // ---------------- reference model (from the requirements) -------------
    logic [10:0] m_rows [7];
    logic [4:0]  m_btn;
    logic [7:0]  m_q [DEP];
    int          m_rd, m_n, m_tc;
    bit          m_ovf;

    // R3 default placement
    function automatic int map_row(input logic [6:0] k);
        int n;
        if (k == 0 || k > 82) return -1;
        n = int'(k) - 1;
        return (n < 77) ? n / 11 : 7;
    endfunction
    function automatic int map_col(input logic [6:0] k);
        int n;
        n = int'(k) - 1;
        return (n < 77) ? n % 11 : n - 77;
    endfunction

    function automatic logic [6:0] exp_sense(input logic [10:0] stb);
        logic [6:0] s;
        for (int r = 0; r < 7; r++) s[r] = |(m_rows[r] & stb);
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 7; r++) m_rows[r] = '0;
            m_btn = '0; m_rd = 0; m_n = 0; m_tc = 0; m_ovf = 0;
        end else begin
            bit tk; int n0, r, c; logic [7:0] h;
            tk = (m_tc == DIV - 1);
            m_tc = tk ? 0 : m_tc + 1;
            if (clear) begin
                for (int i = 0; i < 7; i++) m_rows[i] = '0;
                m_btn = '0; m_rd = 0; m_n = 0; m_ovf = 0;
            end else begin
                n0 = m_n;
                if (evt_valid && n0 == DEP) m_ovf = 1;
                if (evt_valid && n0 < DEP) begin
                    m_q[(m_rd + n0) % DEP] = evt_code;
                    m_n = m_n + 1;
                end
                if (tk && n0 > 0) begin
                    h = m_q[m_rd];
                    m_rd = (m_rd + 1) % DEP;
                    m_n = m_n - 1;
                    r = map_row(h[6:0]);
                    c = map_col(h[6:0]);
                    if (r == 7) m_btn[c] = !h[7];
                    else if (r >= 0) m_rows[r][c] = !h[7];
                end
            end
        end
    end

    // ---------------- checking ---------------------------------------------
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R2 R4 sense", int'(sense_o), int'(exp_sense(strobe_i)));
        chk("R5 button", int'(button_o), int'(m_btn));
        chk("R8 overflow", int'(overflow_o), int'(m_ovf));
    endtask

    task automatic cyc(input bit v, input logic [7:0] code, input bit clr,
                       input logic [10:0] stb);
        @(negedge clk);
        evt_valid = v; evt_code = code; clear = clr; strobe_i = stb;
        #1;
        cmp_model();
    endtask

    task automatic idle(input int n, input logic [10:0] stb);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, stb);
    endtask

    initial begin
        logic [6:0] s_before;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1 sense at reset", int'(sense_o), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 button after reset", int'(button_o), 0);
        chk("R1 overflow after reset", int'(overflow_o), 0);

        // R3: code 0x0D -> n=12 -> row 1, col 1
        cyc(1, 8'h0D, 0, 11'h002);
        chk("R6 not applied on offer cycle", int'(sense_o), 0);
        idle(2 * DIV, 11'h002);
        chk("R3 press lands at row1 col1", int'(sense_o), 7'h02);
        // R2 strobe change shows in the same cycle
        cyc(0, 8'h00, 0, 11'h001);
        chk("R2 other strobe masks key", int'(sense_o), 0);
        cyc(0, 8'h00, 0, 11'h7FF);
        chk("R2 all strobes", int'(sense_o), 7'h02);
        // R4: release via bit 7; same key with bit 7 is 0x8D
        cyc(1, 8'h8D, 0, 11'h7FF);
        idle(2 * DIV, 11'h7FF);
        chk("R4 release clears", int'(sense_o), 0);
        // R3 unmapped codes 0x00 and 0x60 change nothing
        cyc(1, 8'h00, 0, 11'h7FF);
        cyc(1, 8'h60, 0, 11'h7FF);
        idle(3 * DIV, 11'h7FF);
        chk("R3 unmapped dropped sense", int'(sense_o), 0);
        chk("R3 unmapped dropped button", int'(button_o), 0);
        // R5: 0x4E -> n=77 -> button 0; 0x52 -> button 4
        cyc(1, 8'h4E, 0, 11'h7FF);
        cyc(1, 8'h52, 0, 11'h7FF);
        idle(3 * DIV, 11'h7FF);
        chk("R5 buttons pressed", int'(button_o), 5'h11);
        chk("R5 sense untouched", int'(sense_o), 0);
        cyc(1, 8'hCE, 0, 11'h7FF);
        idle(2 * DIV, 11'h7FF);
        chk("R5 button released", int'(button_o), 5'h10);
        // R8: burst of 24 events overruns 16 entries
        for (int i = 0; i < 24; i++) cyc(1, 8'(1 + i), 0, 11'h7FF);
        idle(1, 11'h7FF);
        chk("R8 overflow set", int'(overflow_o), 1);
        idle(5, 11'h7FF);
        chk("R8 overflow sticky", int'(overflow_o), 1);
        // R7 clear
        cyc(1, 8'h0D, 1, 11'h7FF);
        idle(1, 11'h7FF);
        chk("R7 clear sense", int'(sense_o), 0);
        chk("R7 clear buttons", int'(button_o), 0);
        chk("R7 clear overflow", int'(overflow_o), 0);
        s_before = sense_o;
        idle(3 * DIV, 11'h7FF);
        chk("R7 queue emptied and concurrent event discarded", int'(sense_o), int'(s_before));

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit v, c;
            v = ($urandom % 4) == 0;
            c = ($urandom % 300) == 0;
            cyc(v, 8'($urandom), c, 11'($urandom));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule